// File: doc/BRIEF.md
# Timer with Shared Prescaler and Watchdog

This block holds an 8-bit event counter and a watchdog. One programmable prescaler serves either of them. A 7-bit configuration register is loaded from the accumulator bus when `opt_we` is high at a clock edge, and it can only be written. The register chooses four things: the counter's event source (the internal instruction-cycle tick `tick_en` or the external pin `ext_clk`), the active edge of that pin, which of the two consumers owns the prescaler, and a 3-bit ratio code. A sixth field chooses the polarity of the external interrupt edge. The block does not use that field itself. It only stores it and drives it out for the interrupt logic.

The watchdog has a free-running base counter that advances on every clock. When the base counter wraps, that is a watchdog event. If the watchdog owns the prescaler, the events are divided before they set the sticky `wd_timeout` flag. `wd_clear` resets the base counter, the prescaler and the flag. When the counter owns the prescaler, source events are divided before they advance `cnt_q`. When it does not own it, every source event advances `cnt_q`.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready or back-pressure rules apply.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After reset, `cnt_q` is 0, `cnt_wrap` is 0, `wd_timeout` is 0 and `irq_rise_sel` is 0.
- R2: The configuration resets to 7'b0111111. The counter then takes falling edges of `ext_clk` with no division, the watchdog owns the prescaler with code 7 (divide by 128), and `tick_en` has no effect on `cnt_q`.
- R3: When `opt_we` is high at a clock edge, bits 6:0 of `acc_bus` are loaded into the configuration and bit 7 is ignored. The configuration fields are:
  - bit 6: interrupt edge (1 = rising), driven out on `irq_rise_sel` from the next cycle.
  - bit 5: counter source (1 = `ext_clk` pin, 0 = `tick_en`).
  - bit 4: pin edge (1 = falling, 0 = rising).
  - bit 3: prescaler owner (1 = watchdog, 0 = counter).
  - bits 2:0: ratio code.
- R4: When bit 3 is 0, the counter advances once per 2^(code+1) source events (2 to 256) counted since the last `wd_clear`.
- R5: When bit 3 is 1, the counter advances once per source event.
- R6: With the pin source selected, bit 4 = 0 counts only rising transitions of `ext_clk` and bit 4 = 1 counts only falling ones.
- R7: The counter wraps from 0xFF to 0x00. In the cycle where `cnt_q` first reads 0x00 after the wrap, `cnt_wrap` is 1, and it is 0 in the following cycle.
- R8: When bit 3 is 1, `wd_timeout` rises exactly 256·2^code clock edges after the edge that samples `wd_clear`.
- R9: When bit 3 is 0, `wd_timeout` rises exactly 256 edges after `wd_clear`, whatever the code.
- R10: `wd_timeout` stays high until `wd_clear`, and it reads 0 in the cycle after `wd_clear` is sampled.
- R11: A change on `ext_clk` passes through two synchronizer flops and one edge flop. The matching count change is visible after the third rising clock edge following the pin change. A `tick_en` event is visible after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_we | input | 1 | Configuration write strobe |
| acc_bus | input | 8 | Accumulator value to be written |
| tick_en | input | 1 | Internal instruction-cycle tick |
| ext_clk | input | 1 | External counter clock pin, asynchronous |
| wd_clear | input | 1 | Watchdog and prescaler clear |
| cnt_q | output | 8 | Counter value |
| cnt_wrap | output | 1 | One-cycle pulse on counter wrap |
| wd_timeout | output | 1 | Sticky watchdog timeout flag |
| irq_rise_sel | output | 1 | Stored interrupt edge choice, 1 = rising |

## Verification
- **Tick and pin latency:** a tick is driven on a falling clock edge and shows in `cnt_q` at the next falling edge. A pin change is checked as unchanged two cycles later and changed on the third, following the R11 latency.
- **Watchdog timing:** each run starts with a one-cycle `wd_clear`. The bench then counts exactly 256·ratio − 1 cycles and expects `wd_timeout` low, and expects it high one cycle later. A one-cycle error in either direction is therefore caught.
- **Divided counts:** for the random prescaled runs, the bench clears the prescaler first. It then compares the counter delta with the integer quotient of the tick count by the ratio that the bench function computes.
- **Configuration writes:** a configuration write is checked on `irq_rise_sel` one cycle after the strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic       irq_rise;
    logic       src_ext;
    logic       ext_fall;
    logic       pre_wdt;
    logic [2:0] ps_sel;
  } tmr_cfg_t;

  localparam tmr_cfg_t CFG_RST = '{irq_rise: 1'b0, src_ext: 1'b1, ext_fall: 1'b1,
                                   pre_wdt: 1'b1, ps_sel: 3'b111};

  // Terminal value of the prescaler (ratio - 1) for an owner and code.
  function automatic logic [7:0] pre_limit(input logic to_wdt, input logic [2:0] sel);
    logic [8:0] r;
    r = to_wdt ? (9'd1 << sel) : (9'd2 << sel);
    r = r - 9'd1;
    return r[7:0];
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= (i == 0) ? pin : sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise =  sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] &  last_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt_in,
  input  logic [PRE_W-1:0] limit,
  output logic             evt_out
);
  logic [PRE_W-1:0] pre_q;
  logic             at_end;

  assign at_end  = (pre_q >= limit);
  assign evt_out = evt_in & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (evt_in) pre_q <= at_end ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
  parameter int WD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  output logic base_ovf,
  output logic timeout
);
  logic [WD_W-1:0] base_q;

  assign base_ovf = &base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   base_q <= '0;
    else if (clr) base_q <= '0;
    else          base_q <= base_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    timeout <= 1'b0;
    else if (clr)  timeout <= 1'b0;
    else if (fire) timeout <= 1'b1;
  end
endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit #(
  parameter int SYNC_STAGES = 2,
  parameter int WD_W        = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_we,
  input  logic [7:0]       acc_bus,
  input  logic             tick_en,
  input  logic             ext_clk,
  input  logic             wd_clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_wrap,
  output logic             wd_timeout,
  output logic             irq_rise_sel
);
  import tmr_pkg::*;
  localparam int PRE_W = 8;
  localparam int CFG_W = $bits(tmr_cfg_t);

  tmr_cfg_t   cfg_q;
  logic       ext_rise, ext_fallen, src_evt;
  logic       base_ovf, pre_in, pre_out, cnt_inc, wd_fire;
  logic [PRE_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (opt_we) cfg_q <= tmr_cfg_t'(acc_bus[CFG_W-1:0]);
  end

  assign irq_rise_sel = cfg_q.irq_rise;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fallen)
  );

  assign src_evt = cfg_q.src_ext ? (cfg_q.ext_fall ? ext_fallen : ext_rise) : tick_en;
  assign limit   = pre_limit(cfg_q.pre_wdt, cfg_q.ps_sel);
  assign pre_in  = cfg_q.pre_wdt ? base_ovf : src_evt;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wd_clear), .evt_in(pre_in),
    .limit(limit), .evt_out(pre_out)
  );

  assign cnt_inc = cfg_q.pre_wdt ? src_evt : pre_out;
  assign wd_fire = cfg_q.pre_wdt ? pre_out : base_ovf;

  tmr_wdog #(.WD_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clr(wd_clear), .fire(wd_fire),
    .base_ovf(base_ovf), .timeout(wd_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cnt_wrap <= 1'b0;
    end else begin
      cnt_wrap <= cnt_inc & (&cnt_q);
      if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       opt_we,
  input logic [7:0] acc_bus,
  input logic       tick_en,
  input logic       wd_clear,
  input logic [7:0] cnt_q,
  input logic       cnt_wrap,
  input logic       wd_timeout,
  input logic       irq_rise_sel,
  input logic       cfg_src_ext
);
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |-> cnt_q == 8'h00);

  assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> !cnt_wrap);

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == 8'($past(cnt_q) + 8'd1)));

  assert_tick_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_src_ext && !tick_en) |=> $stable(cnt_q));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_timeout && !wd_clear) |=> wd_timeout);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> !wd_timeout);

  assert_irq_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    opt_we |=> irq_rise_sel == $past(acc_bus[6]));
endmodule

bind tmr_wdog_unit tmr_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .acc_bus(acc_bus),
  .tick_en(tick_en), .wd_clear(wd_clear), .cnt_q(cnt_q), .cnt_wrap(cnt_wrap),
  .wd_timeout(wd_timeout), .irq_rise_sel(irq_rise_sel), .cfg_src_ext(cfg_q.src_ext)
);

// File: tb/tmr_wdog_unit_tb.sv
module tmr_wdog_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opt_we = 1'b0;
  logic [7:0] acc_bus = 8'h00;
  logic       tick_en = 1'b0;
  logic       ext_clk = 1'b0;
  logic       wd_clear = 1'b0;
  logic [7:0] cnt_q;
  logic       cnt_wrap, wd_timeout, irq_rise_sel;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_wdog_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .acc_bus(acc_bus),
    .tick_en(tick_en), .ext_clk(ext_clk), .wd_clear(wd_clear),
    .cnt_q(cnt_q), .cnt_wrap(cnt_wrap), .wd_timeout(wd_timeout),
    .irq_rise_sel(irq_rise_sel)
  );

  function automatic int cnt_ratio(input int sel); return 2 << sel; endfunction
  function automatic int wd_ratio(input int sel);  return 1 << sel; endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    opt_we = 1'b1; acc_bus = v; @(negedge clk); opt_we = 1'b0;
  endtask

  task automatic clear_wd();
    wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
  endtask

  task automatic ticks(input int n, input int max_gap);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
      wait_cyc($urandom_range(0, max_gap));
    end
  endtask

  task automatic wd_window(input string req, input int ratio);
    clear_wd();
    wait_cyc(256 * ratio - 1);
    check(req, wd_timeout, 0);
    wait_cyc(1);
    check(req, wd_timeout, 1);
  endtask

  initial begin
    int base, sel, n;
    void'($urandom(32'd1234));
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 cnt", cnt_q, 0);
    check("R1 wrap", cnt_wrap, 0);
    check("R1 timeout", wd_timeout, 0);
    check("R1 irq_sel", irq_rise_sel, 0);

    // R2 defaults: falling pin edges counted undivided, tick ignored
    base = cnt_q;
    ticks(5, 1);
    check("R2 tick ignored", cnt_q, base);
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1'b1; wait_cyc(4);
      ext_clk = 1'b0; wait_cyc(4);
    end
    check("R2 falling edges", cnt_q, base + 3);
    // R2/R8 default watchdog ratio 128
    wd_window("R2 default wdog", 128);

    // R3 config writes, bit 7 ignored
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom());
      write_cfg(v);
      check("R3 irq_sel", irq_rise_sel, int'(v[6]));
    end

    // R6 / R11 rising edge select, latency
    write_cfg(8'h68);             // irq1 src ext, rising, psa wdt
    ext_clk = 1'b0; wait_cyc(6);
    base = cnt_q;
    ext_clk = 1'b1;
    wait_cyc(2);
    check("R11 not yet", cnt_q, base);
    wait_cyc(1);
    check("R11 third edge", cnt_q, base + 1);
    wait_cyc(3);
    ext_clk = 1'b0; wait_cyc(5);
    check("R6 rising ignores fall", cnt_q, base + 1);
    write_cfg(8'hB8);             // bit7 set, src ext, falling, psa wdt
    base = cnt_q;
    ext_clk = 1'b1; wait_cyc(5);
    check("R6 falling ignores rise", cnt_q, base);
    ext_clk = 1'b0; wait_cyc(5);
    check("R6 falling counted", cnt_q, (base + 1) % 256);

    // R5 undivided internal ticks, R11 one-edge latency
    write_cfg(8'h0D);             // internal, psa wdt, code 5
    base = cnt_q;
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    check("R11 tick latency", cnt_q, (base + 1) % 256);
    n = $urandom_range(10, 40);
    base = cnt_q;
    ticks(n, 2);
    check("R5 undivided", cnt_q, (base + n) % 256);

    // R7 wrap
    base = cnt_q;
    ticks((255 - base) % 256, 0);
    check("R7 at ff", cnt_q, 255);
    check("R7 no wrap yet", cnt_wrap, 0);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    check("R7 zero", cnt_q, 0);
    check("R7 wrap pulse", cnt_wrap, 1);
    wait_cyc(1);
    check("R7 wrap ends", cnt_wrap, 0);

    // R4 divided counting, random codes plus corners
    for (int t = 0; t < 8; t++) begin
      sel = (t == 0) ? 0 : (t == 1) ? 7 : $urandom_range(0, 7);
      write_cfg({1'($urandom()), 4'b0000, 3'(sel)});
      clear_wd();
      base = cnt_q;
      n = $urandom_range(0, 600);
      if (t == 1) n = 520;
      ticks(n, 1);
      check("R4 divided", cnt_q, (base + n / cnt_ratio(sel)) % 256);
    end

    // R9 unprescaled watchdog
    write_cfg(8'h06);
    wd_window("R9 wdog no div", 1);
    // R8 prescaled watchdog
    write_cfg(8'h08);
    wd_window("R8 ratio 1", wd_ratio(0));
    write_cfg(8'h0A);
    wd_window("R8 ratio 4", wd_ratio(2));
    // R10 sticky then cleared
    wait_cyc(300);
    check("R10 sticky", wd_timeout, 1);
    clear_wd();
    check("R10 cleared", wd_timeout, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule